// File: doc/BRIEF.md
# Gated Prescaled Timer / Event Counter

This block is a single 8-bit counting channel. It sits behind a 4-bit encoded power-of-two prescaler, so one count step can stand for anywhere from 1 to 32768 qualified events. The full span is therefore 2^15 × 256 input steps. A write-only control byte, loaded through a plain write strobe, sets four things: whether the channel runs, which source it counts, whether gating is on, and one polarity bit.

In timing mode the channel counts pulses of an internal timer-clock strobe. Gating is optional. When it is on, those pulses count only while an external pin sits at a chosen level. In event mode the channel counts a chosen edge of that same pin. The pin passes through a two-flop synchroniser before it is used for gating or for edge detection.

The single polarity bit has two jobs. In event mode it picks the edge. In gated timing mode it picks the gate level. A wrap of the count from 255 to 0 raises a sticky overflow flag, and an explicit clear pulse drops it. Rewriting the control byte restarts the prescaler phase and leaves the count alone.

Top module: `gptmr_top`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0 and every control field is 0, so the channel is stopped.
- R2: With control bit 7 (run) at 0, neither tick pulses nor pin edges change the count.
- R3: Control bits [3:0] hold a code n. The count advances once per 2^n qualified events, for n from 0 (every event) to 15 (every 32768th event).
- R4: With bit 5 = 0 and bit 4 = 0, each tick_in pulse is a qualified event. The pin level and bit 6 have no effect.
- R5: With bit 5 = 0 and bit 4 = 1, a tick_in pulse qualifies only while the synchronised pin equals bit 6 (0 = pin low, 1 = pin high).
- R6: With bit 5 = 1, the qualified events are pin edges: rising when bit 6 = 0, falling when bit 6 = 1. Bit 4 and tick_in have no effect.
- R7: The pin passes through two synchroniser flops. A pin change made just before clock edge k moves the count at clock edge k+2 (prescaler code 0) and not earlier.
- R8: A control write restarts the prescaler phase from zero, does not change the count, and no event counts in the write cycle.
- R9: A count wrap from 255 to 0 sets the overflow flag. The flag stays set until an ovf_clr pulse. A wrap in the same cycle as ovf_clr leaves the flag set.
- R10: The count only ever holds its value or steps up by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte: [7] run, [6] polarity, [5] source, [4] gate enable, [3:0] prescaler code |
| tick_in | input | 1 | Internal timer-clock strobe, one event per high cycle |
| pin_in | input | 1 | Asynchronous external pin |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench aims at the shared polarity bit. A design that decoded it for only one role would count the wrong edge, or would gate on the opposite pin level. Prescaler codes are checked at both ends, including the 32768 limit. If the divider stopped one event early or late, the count would move one step out of place.

A control rewrite in the middle of a prescaler phase is checked. A design that kept the old phase would step the count too soon. The pin-to-count delay is also checked: a missing or extra synchroniser stage would move the count one clock early or late. The bench also drives a wrap on the same cycle as a flag clear. A design where the clear took priority would lose that overflow.

// File: rtl/gptmr_pkg.sv
`timescale 1ns/1ps
package gptmr_pkg;

    parameter int CNT_W  = 8;
    parameter int PSEL_W = 4;
    localparam int PH_W  = (1 << PSEL_W) - 1;

    typedef struct packed {
        logic              run;
        logic              pol;
        logic              ext_src;
        logic              gate_en;
        logic [PSEL_W-1:0] psel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        SRC_FREE  = 2'd0,
        SRC_GATED = 2'd1,
        SRC_EDGE  = 2'd2
    } src_e;

    function automatic src_e decode_src(ctrl_t c);
        if (c.ext_src)      return SRC_EDGE;
        else if (c.gate_en) return SRC_GATED;
        else                return SRC_FREE;
    endfunction

    // terminal phase value for a divisor of 2^s
    function automatic logic [PH_W-1:0] div_mask(logic [PSEL_W-1:0] s);
        logic [PH_W:0] w;
        w = (PH_W+1)'(1) << s;
        w = w - (PH_W+1)'(1);
        return w[PH_W-1:0];
    endfunction

endpackage

// File: rtl/gptmr_sync.sv
`timescale 1ns/1ps
module gptmr_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [SYNC_N:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_N-1:0], pin_in};
    end

    assign lvl  = sh[SYNC_N-1];
    assign rise =  sh[SYNC_N-1] & ~sh[SYNC_N];
    assign fall = ~sh[SYNC_N-1] &  sh[SYNC_N];
endmodule

// File: rtl/gptmr_presc.sv
`timescale 1ns/1ps
module gptmr_presc import gptmr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              evt,
    input  logic [PSEL_W-1:0] psel,
    output logic              carry
);
    logic [PH_W-1:0] ph;

    assign carry = evt & ~restart & (ph == div_mask(psel));

    always_ff @(posedge clk) begin
        if (rst || restart) ph <= '0;
        else if (evt)       ph <= carry ? '0 : ph + 1'b1;
    end
endmodule

// File: rtl/gptmr_cnt.sv
`timescale 1ns/1ps
module gptmr_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr_ovf,
    output logic [W-1:0] count,
    output logic         ovf
);
    logic wrap;
    assign wrap = inc & (count == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (inc) count <= count + 1'b1;
            if (wrap)         ovf <= 1'b1;
            else if (clr_ovf) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/gptmr_top.sv
`timescale 1ns/1ps
module gptmr_top import gptmr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              tick_in,
    input  logic              pin_in,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    ctrl_t cfg_q;
    src_e  mode;
    logic  pin_lvl, pin_rise, pin_fall;
    logic  qual, evt, step;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (wr_en) cfg_q <= ctrl_t'(wr_data);
    end

    gptmr_sync #(.SYNC_N(2)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in),
        .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall)
    );

    assign mode = decode_src(cfg_q);

    always_comb begin
        case (mode)
            SRC_FREE:  qual = tick_in;
            SRC_GATED: qual = tick_in & (pin_lvl == cfg_q.pol);
            SRC_EDGE:  qual = cfg_q.pol ? pin_fall : pin_rise;
            default:   qual = 1'b0;
        endcase
    end

    assign evt = cfg_q.run & qual & ~wr_en;

    gptmr_presc u_presc (
        .clk(clk), .rst(rst), .restart(wr_en), .evt(evt),
        .psel(cfg_q.psel), .carry(step)
    );

    gptmr_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .inc(step), .clr_ovf(ovf_clr),
        .count(count), .ovf(ovf)
    );
endmodule

// File: rtl/gptmr_chk.sv
`timescale 1ns/1ps
module gptmr_chk import gptmr_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             ovf_clr,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);
    assert_step_R10: assert property (@(posedge clk) disable iff (rst)
        (count == $past(count)) || (count == $past(count) + 1'b1));

    assert_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

    assert_write_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(count));

    assert_wrap_sets_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(count) == '1 && count == '0) |-> ovf);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind gptmr_top gptmr_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ovf_clr(ovf_clr),
    .run(cfg_q.run), .count(count), .ovf(ovf)
);

// File: tb/gptmr_top_bench.sv
`timescale 1ns/1ps
module gptmr_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick_in = 1'b0;
    logic       pin_in = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gptmr_top u_gptmr_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tick_in(tick_in), .pin_in(pin_in), .ovf_clr(ovf_clr),
        .count(count), .ovf(ovf)
    );

    function automatic int exp_steps(int nev, int code);
        return nev >> code;
    endfunction

    function automatic bit edge_counts(bit newv, bit pol);
        return pol ? !newv : newv;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    // one configuration segment, checked against the bench model
    task automatic seg(logic [7:0] cfg, bit pin0, int nev, string req);
        int base, q, e;
        wr(8'h00);
        pin_in = pin0;
        cyc(5);
        wr(cfg);
        base = count;
        q = 0;
        if (cfg[5]) begin
            for (int i = 0; i < nev; i++) begin
                @(negedge clk); pin_in = ~pin_in;
                if (edge_counts(pin_in, cfg[6])) q++;
                tick_in = 1'b1;
                @(negedge clk); tick_in = 1'b0;
                cyc(2);
            end
        end else begin
            tick(nev);
            if (!cfg[4] || (pin0 == cfg[6])) q = nev;
        end
        cyc(5);
        e = cfg[7] ? (base + exp_steps(q, cfg[3:0])) & 255 : base;
        check(req, count, e);
    endtask

    initial begin
        int b;
        void'($urandom(32'd4242));
        cyc(3);
        @(negedge clk); rst = 1'b0;
        // R1
        check("R1 count", count, 0);
        check("R1 ovf", ovf, 0);
        tick(4);
        check("R1 stopped", count, 0);

        // R2: run=0, ticks and edges ignored
        seg(8'h00, 1'b0, 10, "R2 timer off");
        seg(8'h20, 1'b0, 6, "R2 events off");

        // R4 ungated, pin either level, pol either way
        seg(8'h80, 1'b1, 7, "R4 pin high");
        seg(8'hC0, 1'b0, 9, "R4 pol set");
        // R5 gated
        seg(8'h90, 1'b0, 5, "R5 low gate open");
        seg(8'h90, 1'b1, 5, "R5 low gate shut");
        seg(8'hD0, 1'b1, 6, "R5 high gate open");
        seg(8'hD0, 1'b0, 6, "R5 high gate shut");
        // R6 edges, bit4 ignored
        seg(8'hA0, 1'b0, 8, "R6 rising");
        seg(8'hE0, 1'b0, 8, "R6 falling");
        seg(8'hB0, 1'b1, 7, "R6 gate bit ignored");
        // R3 small codes
        seg(8'h82, 1'b0, 13, "R3 div4");
        seg(8'hA1, 1'b0, 9, "R3 events div2");

        // R8: write restarts phase, count unchanged
        wr(8'h82);
        tick(3);
        b = count;
        wr(8'h82);
        check("R8 write keeps count", count, b);
        tick(3);
        cyc(2);
        check("R8 phase restarted", count, b);
        tick(1);
        cyc(1);
        check("R8 step after 4", count, (b + 1) & 255);

        // R7 synchroniser latency
        wr(8'h00); pin_in = 1'b0; cyc(5);
        wr(8'hA0);
        b = count;
        @(negedge clk); pin_in = 1'b1;
        @(negedge clk);
        check("R7 edge+1", count, b);
        @(negedge clk);
        check("R7 edge+2 pre", count, b);
        @(negedge clk);
        check("R7 edge+2", count, (b + 1) & 255);

        // R9 overflow
        wr(8'h80);
        @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R9 cleared", ovf, 0);
        tick(255 - count);
        cyc(1);
        check("R9 at 255", count, 255);
        check("R9 no flag yet", ovf, 0);
        tick(1);
        cyc(1);
        check("R9 wrapped", count, 0);
        check("R9 flag set", ovf, 1);
        tick(5);
        check("R9 sticky", ovf, 1);
        @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
        check("R9 clear", ovf, 0);
        tick(255 - count);
        @(negedge clk); tick_in = 1'b1; ovf_clr = 1'b1;
        @(negedge clk); tick_in = 1'b0; ovf_clr = 1'b0;
        check("R9 set wins", ovf, 1);

        // R3 largest code: 32768 events per step
        wr(8'h8F);
        b = count;
        @(negedge clk); tick_in = 1'b1;
        cyc(32767);
        check("R3 div32768 not yet", count, b);
        @(negedge clk); tick_in = 1'b0;
        check("R3 div32768 step", count, (b + 1) & 255);

        // constrained random segments
        for (int k = 0; k < 40; k++) begin
            logic [7:0] c;
            c = 8'($urandom);
            c[3:0] = 4'($urandom_range(0, 3));
            seg(c, 1'($urandom), int'($urandom_range(1, 40)), "R3-mix random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule